// File: doc/BRIEF.md
# Reflectable Playfield Bit Serializer

This block produces the background playfield pixel stream of one scanline. Software loads three pattern registers and one control register through a small register write port. A horizontal cell position input names the visible cell being drawn, one of 40 per line. For each presented cell the block returns one playfield-on bit, a 2-bit colour-source select and a priority flag, one clock later, for a downstream video mixer.

The 20 cells of a half-line come from three registers. Their bit orders alternate: the first group of 4 cells is read upward from the top nibble, the middle group of 8 is read downward, and the last group of 8 is read upward. The right half of the line either repeats the left-half pattern or mirrors it. A score mode tells the mixer to colour the left half with player 0's colour and the right half with player 1's colour. A priority flag tells the mixer to draw the playfield over the movable objects.

A three-state machine tracks the phase of the cell being output. The states are `PH_BLANK`, `PH_LEFT` and `PH_RIGHT`. The state entered on each clock is set by the presented position:
- BLANK→LEFT when a visible cell below 20 arrives.
- LEFT→RIGHT when cell 20 arrives.
- RIGHT→BLANK after cell 39, or when the valid input drops.

Any state goes to BLANK on an invalid or out-of-range position. Any state goes to LEFT or RIGHT when a cell of that half is presented, for example BLANK→RIGHT on a jump straight into the right half.

Top module: `pf_serializer`

## Requirements
- R1: After reset all registers are zero. `pf_on`, `pf_color_sel` and `pf_priority` are 0, and every cell reads dark until a register is written.
- R2: A write to address 0 stores data bits 7:4 as cells 0..3. Bit 4 is cell 0 and bit 7 is cell 3. Data bits 3:0 have no effect.
- R3: A write to address 1 stores cells 4..11 most-significant bit first. Data bit 7 is cell 4 and bit 0 is cell 11.
- R4: A write to address 2 stores cells 12..19 least-significant bit first. Data bit 0 is cell 12 and bit 7 is cell 19.
- R5: When control bit 0 (address 3) is 0, cell 20+k shows the same bit as cell k, for k = 0..19.
- R6: When control bit 0 is 1, the right half is mirrored. Cell 20+k shows the bit of cell 19-k, so cell 20 shows cell 19 and cell 39 shows cell 0.
- R7: `pf_color_sel` encodes the colour source: 00 = own playfield colour, 01 = player 0 colour, 10 = player 1 colour; 11 is never produced. With control bit 1 set, left-half cells give 01 and right-half cells give 10. With it clear, visible cells give 00. Blank cells always give 00.
- R8: `pf_priority` equals control bit 2 as it stood when the current cell was presented.
- R9: When `cell_valid` is low or `cell_idx` is 40 or above, `pf_on` is 0 and `pf_color_sel` is 00 for that cell.
- R10: The result for a cell presented in cycle n appears after the clock edge that ends cycle n. A register write in cycle n is used from the cell presented in cycle n+1 onward, so a mid-line write changes the remaining cells of the line.
- R11: With `wr_en` low, the address and data inputs have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0,1,2 pattern groups, 3 control |
| wr_data | input | 8 | Register write data |
| cell_valid | input | 1 | High when the presented position is in the visible line |
| cell_idx | input | 6 | Visible cell position, 0..39 |
| pf_on | output | 1 | Playfield bit for the previous cycle's cell |
| pf_color_sel | output | 2 | Colour source select for that cell |
| pf_priority | output | 1 | Playfield-over-objects flag |

## Verification
Every result is due exactly one clock after its cell is presented, and a write is seen by the cell presented one cycle after the write. The bench therefore drives one cell or one write per cycle just after a rising edge. It samples outputs one nanosecond after the next rising edge, which is the earliest point where that cell's result is valid. The mid-line write test presents a write together with a cell. It expects the old value for that cell and the new value for the following cell. This pins down the single-register latency on both the data path and the register path.

// File: rtl/pf_pkg.sv
package pf_pkg;

    localparam int unsigned PF_REG_W       = 8;
    localparam int unsigned PF_GRP_A_CELLS = 4;
    localparam int unsigned PF_ADDR_W      = 2;

    // Phase of the cell currently held in the output stage
    typedef enum logic [1:0] {
        PH_BLANK = 2'd0,
        PH_LEFT  = 2'd1,
        PH_RIGHT = 2'd2
    } pf_phase_e;

    // Register addresses
    typedef enum logic [1:0] {
        RA_GRP_A = 2'd0,
        RA_GRP_B = 2'd1,
        RA_GRP_C = 2'd2,
        RA_CTRL  = 2'd3
    } pf_reg_e;

    typedef struct packed {
        logic over_objects;   // data bit 2
        logic score_mode;     // data bit 1
        logic mirror;         // data bit 0
    } pf_ctrl_t;

    localparam logic [1:0] CSEL_OWN          = 2'b00;
    localparam logic [1:0] CSEL_LEFT_PLAYER  = 2'b01;
    localparam logic [1:0] CSEL_RIGHT_PLAYER = 2'b10;

endpackage

// File: rtl/pf_regfile.sv
module pf_regfile
    import pf_pkg::*;
#(
    parameter int unsigned REG_W   = PF_REG_W,
    parameter int unsigned A_CELLS = PF_GRP_A_CELLS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PF_ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]     wr_data,
    output logic [A_CELLS-1:0]   grp_a,
    output logic [REG_W-1:0]     grp_b,
    output logic [REG_W-1:0]     grp_c,
    output pf_ctrl_t             ctrl
);

    // Only the upper A_CELLS bits of the first group are kept
    localparam int unsigned A_TOP = REG_W - 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_a <= '0;
            grp_b <= '0;
            grp_c <= '0;
            ctrl  <= '0;
        end else if (wr_en) begin
            unique case (pf_reg_e'(wr_addr))
                RA_GRP_A: grp_a <= wr_data[A_TOP -: A_CELLS];
                RA_GRP_B: grp_b <= wr_data;
                RA_GRP_C: grp_c <= wr_data;
                RA_CTRL: begin
                    ctrl.over_objects <= wr_data[2];
                    ctrl.score_mode   <= wr_data[1];
                    ctrl.mirror       <= wr_data[0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pf_pattern_build.sv
module pf_pattern_build #(
    parameter int unsigned A_CELLS = 4,
    parameter int unsigned B_CELLS = 8,
    parameter int unsigned C_CELLS = 8
) (
    input  logic [A_CELLS-1:0]                   grp_a,
    input  logic [B_CELLS-1:0]                   grp_b,
    input  logic [C_CELLS-1:0]                   grp_c,
    output logic [A_CELLS+B_CELLS+C_CELLS-1:0]   pattern
);

    // pattern[i] is half-line cell i, cell 0 leftmost
    for (genvar i = 0; i < A_CELLS; i++) begin : g_grp_a
        assign pattern[i] = grp_a[i];
    end

    // middle group runs high bit first
    for (genvar j = 0; j < B_CELLS; j++) begin : g_grp_b
        assign pattern[A_CELLS + j] = grp_b[B_CELLS - 1 - j];
    end

    // last group runs low bit first
    for (genvar k = 0; k < C_CELLS; k++) begin : g_grp_c
        assign pattern[A_CELLS + B_CELLS + k] = grp_c[k];
    end

endmodule

// File: rtl/pf_cell_select.sv
module pf_cell_select
    import pf_pkg::*;
#(
    parameter int unsigned HALF  = 20,
    parameter int unsigned POS_W = $clog2(2 * HALF)
) (
    input  logic             cell_valid,
    input  logic [POS_W-1:0] cell_idx,
    input  logic [HALF-1:0]  pattern,
    input  logic             mirror,
    output pf_phase_e        phase_next,
    output logic             cell_bit
);

    localparam int unsigned IDX_W = $clog2(HALF);
    localparam logic [POS_W-1:0] HALF_P = POS_W'(HALF);
    localparam logic [POS_W-1:0] LINE_P = POS_W'(2 * HALF);
    localparam logic [IDX_W-1:0] LAST_I = IDX_W'(HALF - 1);

    logic [POS_W-1:0] right_off;
    logic [IDX_W-1:0] half_idx;

    assign right_off = cell_idx - HALF_P;

    always_comb begin
        phase_next = PH_BLANK;
        half_idx   = '0;
        if (cell_valid) begin
            if (cell_idx < HALF_P) begin
                phase_next = PH_LEFT;
                half_idx   = IDX_W'(cell_idx);
            end else if (cell_idx < LINE_P) begin
                phase_next = PH_RIGHT;
                half_idx   = mirror ? (LAST_I - IDX_W'(right_off))
                                    : IDX_W'(right_off);
            end
        end
    end

    assign cell_bit = (phase_next != PH_BLANK) && pattern[half_idx];

endmodule

// File: rtl/pf_serializer.sv
module pf_serializer
    import pf_pkg::*;
#(
    parameter int unsigned REG_W   = PF_REG_W,
    parameter int unsigned A_CELLS = PF_GRP_A_CELLS,
    parameter int unsigned POS_W   = $clog2(2 * (A_CELLS + 2 * REG_W))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             cell_valid,
    input  logic [POS_W-1:0] cell_idx,
    output logic             pf_on,
    output logic [1:0]       pf_color_sel,
    output logic             pf_priority
);

    localparam int unsigned HALF = A_CELLS + 2 * REG_W;

    logic [A_CELLS-1:0] grp_a;
    logic [REG_W-1:0]   grp_b;
    logic [REG_W-1:0]   grp_c;
    pf_ctrl_t           ctrl;
    logic [HALF-1:0]    pattern_w;
    pf_phase_e          phase_next;
    logic               cell_bit;

    pf_phase_e state, state_d;
    logic      bit_q;
    logic      score_q;
    logic      prio_q;

    pf_regfile #(
        .REG_W   (REG_W),
        .A_CELLS (A_CELLS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .grp_a   (grp_a),
        .grp_b   (grp_b),
        .grp_c   (grp_c),
        .ctrl    (ctrl)
    );

    pf_pattern_build #(
        .A_CELLS (A_CELLS),
        .B_CELLS (REG_W),
        .C_CELLS (REG_W)
    ) u_build (
        .grp_a   (grp_a),
        .grp_b   (grp_b),
        .grp_c   (grp_c),
        .pattern (pattern_w)
    );

    pf_cell_select #(
        .HALF  (HALF),
        .POS_W (POS_W)
    ) u_select (
        .cell_valid (cell_valid),
        .cell_idx   (cell_idx),
        .pattern    (pattern_w),
        .mirror     (ctrl.mirror),
        .phase_next (phase_next),
        .cell_bit   (cell_bit)
    );

    // Transitions: the presented position decides the next phase
    always_comb begin
        unique case (state)
            PH_BLANK: state_d = phase_next;   // BLANK->LEFT / BLANK->RIGHT
            PH_LEFT:  state_d = phase_next;   // LEFT->RIGHT at the half boundary
            PH_RIGHT: state_d = phase_next;   // RIGHT->BLANK past the last cell
            default:  state_d = PH_BLANK;
        endcase
    end

    // State register with the cell payload captured alongside
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PH_BLANK;
            bit_q   <= 1'b0;
            score_q <= 1'b0;
            prio_q  <= 1'b0;
        end else begin
            state   <= state_d;
            bit_q   <= cell_bit;
            score_q <= ctrl.score_mode;
            prio_q  <= ctrl.over_objects;
        end
    end

    // Outputs
    always_comb begin
        pf_on        = 1'b0;
        pf_color_sel = CSEL_OWN;
        unique case (state)
            PH_BLANK: ;
            PH_LEFT: begin
                pf_on        = bit_q;
                pf_color_sel = score_q ? CSEL_LEFT_PLAYER : CSEL_OWN;
            end
            PH_RIGHT: begin
                pf_on        = bit_q;
                pf_color_sel = score_q ? CSEL_RIGHT_PLAYER : CSEL_OWN;
            end
            default: ;
        endcase
    end

    assign pf_priority = prio_q;

endmodule

// File: rtl/pf_serializer_chk.sv
module pf_serializer_chk #(
    parameter int unsigned POS_W = 6,
    parameter int unsigned HALF  = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [7:0]       wr_data,
    input logic             cell_valid,
    input logic [POS_W-1:0] cell_idx,
    input logic             pf_on,
    input logic [1:0]       pf_color_sel,
    input logic             pf_priority,
    input logic [HALF-1:0]  pattern
);

    a_r9_invalid_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_valid |=> (!pf_on && pf_color_sel == 2'b00));

    a_r9_past_end_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_valid && cell_idx >= POS_W'(2 * HALF)) |=> !pf_on);

    a_r7_no_code_three: assert property (@(posedge clk) disable iff (!rst_n)
        pf_color_sel != 2'b11);

    a_r8_prio_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3) |=> ##1 (pf_priority == $past(wr_data[2], 2)));

    a_r2_top_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0) |=> (pattern[3:0] == $past(wr_data[7:4])));

    a_r11_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pattern));

endmodule

bind pf_serializer pf_serializer_chk #(
    .POS_W (POS_W),
    .HALF  (HALF)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .cell_valid   (cell_valid),
    .cell_idx     (cell_idx),
    .pf_on        (pf_on),
    .pf_color_sel (pf_color_sel),
    .pf_priority  (pf_priority),
    .pattern      (pattern_w)
);

// File: tb/test_pf_serializer.sv
`timescale 1ns/1ps
module test_pf_serializer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       cell_valid = 1'b0;
    logic [5:0] cell_idx = 6'd0;
    logic       pf_on;
    logic [1:0] pf_color_sel;
    logic       pf_priority;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pf_serializer i_pf_serializer (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .cell_valid   (cell_valid),
        .cell_idx     (cell_idx),
        .pf_on        (pf_on),
        .pf_color_sel (pf_color_sel),
        .pf_priority  (pf_priority)
    );

    // {grp0, grp1, grp2, ctrl}
    localparam logic [31:0] CFG_TBL [6] = '{
        32'hF0000000,
        32'h10800101,
        32'h8F018000,
        32'hA55AC303,
        32'h60F00F04,
        32'h30966907
    };

    task automatic chk_eq(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs, then sample just after the closing edge
    task automatic step(input bit v, input int idx, input bit we,
                        input int addr, input int data);
        cell_valid = v;
        cell_idx   = 6'(idx);
        wr_en      = we;
        wr_addr    = 2'(addr);
        wr_data    = 8'(data);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic wr(input int addr, input int data);
        step(1'b0, 0, 1'b1, addr, data);
    endtask

    function automatic int exp_bit(input logic [31:0] cfg, input int idx);
        int h;
        if (idx < 20)      h = idx;
        else if (cfg[0])   h = 39 - idx;
        else               h = idx - 20;
        if (h < 4)         return int'(cfg[24 + 4 + h]);
        else if (h < 12)   return int'(cfg[16 + 11 - h]);
        else               return int'(cfg[8 + h - 12]);
    endfunction

    function automatic int exp_sel(input logic [31:0] cfg, input int idx);
        if (!cfg[1]) return 0;
        return (idx < 20) ? 1 : 2;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk_eq("R1 on", int'(pf_on), 0);
        chk_eq("R1 sel", int'(pf_color_sel), 0);
        chk_eq("R1 prio", int'(pf_priority), 0);
        rst_n = 1'b1;
        for (int x = 0; x < 40; x += 7) begin
            step(1'b1, x, 1'b0, 0, 0);
            chk_eq("R1 dark", int'(pf_on), 0);
        end

        // Table walk: R2..R8
        for (int n = 0; n < 6; n++) begin
            logic [31:0] cfg;
            cfg = CFG_TBL[n];
            wr(0, int'(cfg[31:24]));
            wr(1, int'(cfg[23:16]));
            wr(2, int'(cfg[15:8]));
            wr(3, int'(cfg[7:0]));
            for (int x = 0; x < 40; x++) begin
                string tag;
                step(1'b1, x, 1'b0, 0, 0);
                if (x < 4)        tag = "R2";
                else if (x < 12)  tag = "R3";
                else if (x < 20)  tag = "R4";
                else if (cfg[0])  tag = "R6";
                else              tag = "R5";
                chk_eq(tag, int'(pf_on), exp_bit(cfg, x));
                chk_eq("R7", int'(pf_color_sel), exp_sel(cfg, x));
                chk_eq("R8", int'(pf_priority), int'(cfg[2]));
            end
        end

        // R9: blanking with everything lit and score mode on
        wr(0, 8'hF0); wr(1, 8'hFF); wr(2, 8'hFF); wr(3, 8'h02);
        step(1'b0, 5, 1'b0, 0, 0);
        chk_eq("R9 invalid on", int'(pf_on), 0);
        chk_eq("R9 invalid sel", int'(pf_color_sel), 0);
        step(1'b1, 45, 1'b0, 0, 0);
        chk_eq("R9 range on", int'(pf_on), 0);
        chk_eq("R9 range sel", int'(pf_color_sel), 0);
        step(1'b1, 5, 1'b0, 0, 0);
        chk_eq("R9 visible on", int'(pf_on), 1);
        chk_eq("R7 visible sel", int'(pf_color_sel), 1);

        // R10: write alongside cell 10 clears grp1; cell 10 still old, cell 11 new
        wr(3, 8'h00);
        step(1'b1, 10, 1'b1, 1, 8'h00);
        chk_eq("R10 old value", int'(pf_on), 1);
        step(1'b1, 11, 1'b0, 0, 0);
        chk_eq("R10 new value", int'(pf_on), 0);
        step(1'b1, 31, 1'b0, 0, 0);
        chk_eq("R10 rest of line", int'(pf_on), 0);

        // R11: disabled write must not clear grp2 or ctrl
        step(1'b1, 13, 1'b0, 2, 8'h00);
        step(1'b1, 14, 1'b0, 3, 8'h07);
        chk_eq("R11 grp2 held", int'(pf_on), 1);
        step(1'b1, 39, 1'b0, 0, 0);
        chk_eq("R11 ctrl held", int'(pf_color_sel), 0);
        chk_eq("R11 prio held", int'(pf_priority), 0);

        // R2: low nibble of grp0 is ignored
        wr(0, 8'h0F);
        step(1'b1, 0, 1'b0, 0, 0);
        chk_eq("R2 low nibble", int'(pf_on), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule